// File: doc/BRIEF.md
# Functional Reset Event Router

The block sits between a set of functional reset sources and the reset phase sequencer. Each source request is routed one of three ways: it starts a reset sequence, it raises a SAFE-mode request, or it raises an interrupt request. Per-source configuration sits behind a small write port. There are three configuration registers: a mask that turns a source from a reset into an alternate event, a select that picks SAFE mode or interrupt for a masked source, and a short-sequence bit that makes a reset begin at PHASE3 instead of PHASE1. The mask register takes only one write after each power-on reset.

A reset start is a one-cycle pulse with a flag that gives the starting phase. The alternate requests are levels. They are formed combinationally from the source lines and sticky per-source status bits, so they do not depend on the clock. Software clears a status bit by writing 1 to it. While the sequencer reports PHASE1, source assertions set no status bit and raise no alternate request.

Register addresses: 0 = mask (write-once), 1 = alternate select, 2 = short-sequence, 3 = status clear (write 1 to clear). Phase encoding on `cur_phase`: 0 idle, 1 PHASE1, 2 PHASE2, 3 PHASE3. The synchronous reset `rst` stands for the power-on reset.

Top module: `func_reset_router`

## Requirements
- R1: A source whose mask bit is 0 never contributes to `safe_req` or `irq_req`, whatever its select bit holds.
- R2: A source whose mask bit is 1 drives `safe_req` when its select bit is 0 and `irq_req` when its select bit is 1. This happens in the same cycle as the source asserts, provided `cur_phase` is not 1.
- R3: After a reset, the first write to address 0 loads the mask. Every later write to address 0 is ignored until the next reset.
- R4: A rising edge on a source whose mask bit is 0 gives `seq_start` high for exactly the cycle after the edge is sampled. A masked source never gives `seq_start`.
- R5: When `seq_start` is high, `seq_start_ph3` is 1 only if every unmasked source that rose in that event has its short-sequence bit set. Otherwise it is 0, which means PHASE1.
- R6: While `cur_phase` is 1, an asserted source sets no status bit, and a masked source raises no alternate request unless its status bit was already set.
- R7: An alternate request stays asserted until both of these are true: the source is low, and its status bit has been cleared.
- R8: A status bit is set on every clock edge where its source is high and `cur_phase` is not 1. It is cleared by writing 1 to that bit at address 3. If a set and a clear happen in the same cycle, the set wins.
- R9: `safe_req` is the OR over all masked sources selected for SAFE mode, and `irq_req` is the OR over all masked sources selected for interrupt.
- R10: After reset, all configuration and status bits are 0, the mask is writable again, and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| src_req | input | NUM_SRC | Functional reset source requests |
| cur_phase | input | 2 | Current phase from the external sequencer |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | NUM_SRC | Register write data, one bit per source |
| seq_start | output | 1 | Reset sequence start pulse |
| seq_start_ph3 | output | 1 | Start phase with the pulse: 1 = PHASE3, 0 = PHASE1 |
| safe_req | output | 1 | SAFE-mode request level |
| irq_req | output | 1 | Interrupt request level |
| evt_status | output | NUM_SRC | Sticky per-source status bits |

## Verification
The assertions check the following on every cycle:
- unmasked sources never produce alternate requests;
- a locked mask never changes on a write;
- no status bit rises while the sequencer is in PHASE1;
- status bits only fall through a clear;
- a start pulse always follows source activity, and the PHASE3 flag never appears without it.

Some behaviours only the bench scenarios can show:
- the exact routing of each source to SAFE mode or interrupt;
- the start-phase choice when several sources rise together with mixed short-sequence bits;
- a request held through a clear while its source is still high;
- the mask becoming writable again after a second reset.

// File: rtl/frr_pkg.sv
package frr_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ONE   = 2'd1,
        PH_TWO   = 2'd2,
        PH_THREE = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        REG_MASK   = 2'd0,
        REG_ALTSEL = 2'd1,
        REG_SHORT  = 2'd2,
        REG_CLEAR  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic fire;
        logic at_ph3;
    } seq_req_t;

    function automatic logic in_phase_one(input phase_e p);
        return p == PH_ONE;
    endfunction

endpackage

// File: rtl/frr_cfg_regs.sv
module frr_cfg_regs
    import frr_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  reg_addr_e          wr_addr,
    input  logic [NUM_SRC-1:0] wr_data,
    output logic [NUM_SRC-1:0] mask_q,
    output logic [NUM_SRC-1:0] altsel_q,
    output logic [NUM_SRC-1:0] short_q
);

    logic mask_locked;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q      <= '0;
            altsel_q    <= '0;
            short_q     <= '0;
            mask_locked <= 1'b0;
        end else if (wr_en) begin
            case (wr_addr)
                REG_MASK: begin
                    if (!mask_locked) begin
                        mask_q      <= wr_data;
                        mask_locked <= 1'b1;
                    end
                end
                REG_ALTSEL: altsel_q <= wr_data;
                REG_SHORT:  short_q  <= wr_data;
                default: ;
            endcase
        end
    end

    AST_MASK_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (mask_locked && wr_en && wr_addr == REG_MASK) |=> $stable(mask_q)); // R3

    AST_LOCK_STAYS: assert property (@(posedge clk) disable iff (rst)
        mask_locked |=> mask_locked); // R3

endmodule

// File: rtl/frr_status.sv
module frr_status
    import frr_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_req,
    input  phase_e             phase,
    input  logic               wr_en,
    input  reg_addr_e          wr_addr,
    input  logic [NUM_SRC-1:0] wr_data,
    output logic [NUM_SRC-1:0] status_q
);

    logic [NUM_SRC-1:0] set_mask;
    logic [NUM_SRC-1:0] clr_mask;

    assign set_mask = in_phase_one(phase) ? '0 : src_req;
    assign clr_mask = (wr_en && wr_addr == REG_CLEAR) ? wr_data : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
        end else begin
            status_q <= (status_q & ~clr_mask) | set_mask;
        end
    end

    AST_NO_SET_IN_PH1: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_ONE) |=> ((status_q & ~$past(status_q)) == '0)); // R6

    AST_STICKY_BITS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(status_q) & ~status_q & ~$past(clr_mask)) == '0)); // R8

endmodule

// File: rtl/frr_route.sv
module frr_route
    import frr_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_req,
    input  phase_e             phase,
    input  logic [NUM_SRC-1:0] mask_q,
    input  logic [NUM_SRC-1:0] altsel_q,
    input  logic [NUM_SRC-1:0] short_q,
    input  logic [NUM_SRC-1:0] status_q,
    output seq_req_t           seq_q,
    output logic               safe_req,
    output logic               irq_req
);

    logic [NUM_SRC-1:0] src_q;
    logic [NUM_SRC-1:0] rst_rise;
    logic [NUM_SRC-1:0] alt_live;
    logic [NUM_SRC-1:0] to_safe;
    logic [NUM_SRC-1:0] to_irq;
    logic               ph1;

    assign ph1 = in_phase_one(phase);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign rst_rise[i] = src_req[i] & ~src_q[i] & ~mask_q[i];
        assign alt_live[i] = mask_q[i] & (status_q[i] | (src_req[i] & ~ph1));
        assign to_safe[i]  = alt_live[i] & ~altsel_q[i];
        assign to_irq[i]   = alt_live[i] & altsel_q[i];
    end

    assign safe_req = |to_safe;
    assign irq_req  = |to_irq;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q <= '0;
            seq_q <= '0;
        end else begin
            src_q        <= src_req;
            seq_q.fire   <= |rst_rise;
            seq_q.at_ph3 <= (|rst_rise) && ((rst_rise & ~short_q) == '0);
        end
    end

    AST_NO_ALT_UNMASKED: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |-> (!safe_req && !irq_req)); // R1

    AST_PH3_NEEDS_FIRE: assert property (@(posedge clk) disable iff (rst)
        seq_q.at_ph3 |-> seq_q.fire); // R5

    AST_FIRE_FROM_SRC: assert property (@(posedge clk) disable iff (rst)
        seq_q.fire |-> $past(|src_req)); // R4

endmodule

// File: rtl/func_reset_router.sv
module func_reset_router
    import frr_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic [1:0]         cur_phase,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [NUM_SRC-1:0] wr_data,
    output logic               seq_start,
    output logic               seq_start_ph3,
    output logic               safe_req,
    output logic               irq_req,
    output logic [NUM_SRC-1:0] evt_status
);

    phase_e             phase;
    reg_addr_e          addr;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] altsel_q;
    logic [NUM_SRC-1:0] short_q;
    logic [NUM_SRC-1:0] status_q;
    seq_req_t           seq_q;

    assign phase = phase_e'(cur_phase);
    assign addr  = reg_addr_e'(wr_addr);

    frr_cfg_regs #(.NUM_SRC(NUM_SRC)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (addr),
        .wr_data  (wr_data),
        .mask_q   (mask_q),
        .altsel_q (altsel_q),
        .short_q  (short_q)
    );

    frr_status #(.NUM_SRC(NUM_SRC)) u_status (
        .clk      (clk),
        .rst      (rst),
        .src_req  (src_req),
        .phase    (phase),
        .wr_en    (wr_en),
        .wr_addr  (addr),
        .wr_data  (wr_data),
        .status_q (status_q)
    );

    frr_route #(.NUM_SRC(NUM_SRC)) u_route (
        .clk      (clk),
        .rst      (rst),
        .src_req  (src_req),
        .phase    (phase),
        .mask_q   (mask_q),
        .altsel_q (altsel_q),
        .short_q  (short_q),
        .status_q (status_q),
        .seq_q    (seq_q),
        .safe_req (safe_req),
        .irq_req  (irq_req)
    );

    assign seq_start     = seq_q.fire;
    assign seq_start_ph3 = seq_q.at_ph3;
    assign evt_status    = status_q;

endmodule

// File: tb/func_reset_router_tb_top.sv
module func_reset_router_tb_top;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] src_req = '0;
    logic [1:0]   cur_phase = 2'd0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_addr = 2'd0;
    logic [N-1:0] wr_data = '0;
    logic         seq_start, seq_start_ph3, safe_req, irq_req;
    logic [N-1:0] evt_status;

    int checks = 0;
    int errors = 0;

    logic [N-1:0] m_dis, m_sel, m_short, m_status, m_prev;
    logic         m_lock, exp_fire, exp_ph3;

    always #5 clk = ~clk;

    func_reset_router #(.NUM_SRC(N)) dut_i (
        .clk(clk), .rst(rst), .src_req(src_req), .cur_phase(cur_phase),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .seq_start(seq_start), .seq_start_ph3(seq_start_ph3),
        .safe_req(safe_req), .irq_req(irq_req), .evt_status(evt_status)
    );

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [N-1:0] alt_live(logic [N-1:0] src, logic [1:0] ph);
        return m_dis & (m_status | (src & ((ph != 2'd1) ? {N{1'b1}} : {N{1'b0}})));
    endfunction

    task automatic step(logic [N-1:0] src, logic [1:0] ph, logic we,
                        logic [1:0] a, logic [N-1:0] d, string tag);
        logic [N-1:0] live, rr, clr;
        @(negedge clk);
        src_req = src; cur_phase = ph; wr_en = we; wr_addr = a; wr_data = d;
        #1;
        live = alt_live(src, ph);
        chk(tag, "safe_req", {31'd0, safe_req}, {31'd0, |(live & ~m_sel)});
        chk(tag, "irq_req", {31'd0, irq_req}, {31'd0, |(live & m_sel)});
        chk(tag, "seq_start", {31'd0, seq_start}, {31'd0, exp_fire});
        if (exp_fire) chk(tag, "seq_start_ph3", {31'd0, seq_start_ph3}, {31'd0, exp_ph3});
        chk(tag, "evt_status", {24'd0, evt_status}, {24'd0, m_status});
        rr       = src & ~m_prev & ~m_dis;
        exp_fire = |rr;
        exp_ph3  = (|rr) && ((rr & ~m_short) == '0);
        clr      = (we && a == 2'd3) ? d : '0;
        m_status = (m_status & ~clr) | ((ph != 2'd1) ? src : '0);
        if (we) begin
            case (a)
                2'd0: if (!m_lock) begin m_dis = d; m_lock = 1'b1; end
                2'd1: m_sel = d;
                2'd2: m_short = d;
                default: ;
            endcase
        end
        m_prev = src;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; src_req = '0; wr_en = 1'b0; cur_phase = 2'd0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_dis = '0; m_sel = '0; m_short = '0; m_status = '0; m_prev = '0;
        m_lock = 1'b0; exp_fire = 1'b0; exp_ph3 = 1'b0;
        #1;
        // R10 reset state
        chk("R10", "seq_start", {31'd0, seq_start}, 32'd0);
        chk("R10", "safe_req", {31'd0, safe_req}, 32'd0);
        chk("R10", "irq_req", {31'd0, irq_req}, 32'd0);
        chk("R10", "evt_status", {24'd0, evt_status}, 32'd0);
    endtask

    initial begin
        #500us;
        errors++;
        $display("FAIL watchdog act=running exp=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();

        // R1: unmasked source with select=1 still resets, never alternates
        step(8'h00, 2'd0, 1'b1, 2'd1, 8'hFF, "R1");
        step(8'h01, 2'd2, 1'b0, 2'd0, 8'h00, "R1");
        step(8'h01, 2'd2, 1'b0, 2'd0, 8'h00, "R4");
        step(8'h00, 2'd2, 1'b0, 2'd0, 8'h00, "R4");

        // R5: short-sequence mix decides the start phase
        step(8'h00, 2'd0, 1'b1, 2'd2, 8'h06, "R5");
        step(8'h02, 2'd3, 1'b0, 2'd0, 8'h00, "R5");
        step(8'h00, 2'd3, 1'b0, 2'd0, 8'h00, "R5");
        step(8'h06, 2'd3, 1'b0, 2'd0, 8'h00, "R5");
        step(8'h00, 2'd3, 1'b0, 2'd0, 8'h00, "R5");
        step(8'h03, 2'd2, 1'b0, 2'd0, 8'h00, "R5");
        step(8'h00, 2'd2, 1'b1, 2'd3, 8'hFF, "R5");

        // R3: the first mask write sticks, the second is dropped
        step(8'h00, 2'd0, 1'b1, 2'd0, 8'h30, "R3");
        step(8'h00, 2'd0, 1'b1, 2'd0, 8'h00, "R3");
        step(8'h10, 2'd2, 1'b0, 2'd0, 8'h00, "R3");
        step(8'h00, 2'd2, 1'b0, 2'd0, 8'h00, "R3");
        step(8'h00, 2'd2, 1'b1, 2'd3, 8'h10, "R8");

        // R2: masked source 5 with select 0 goes to SAFE mode
        step(8'h00, 2'd0, 1'b1, 2'd1, 8'hDF, "R2");
        step(8'h20, 2'd2, 1'b0, 2'd0, 8'h00, "R2");
        // R7 / R8: clear while source high, set wins, request held
        step(8'h20, 2'd2, 1'b1, 2'd3, 8'h20, "R8");
        step(8'h00, 2'd2, 1'b0, 2'd0, 8'h00, "R7");
        step(8'h00, 2'd2, 1'b1, 2'd3, 8'h20, "R7");
        step(8'h00, 2'd2, 1'b0, 2'd0, 8'h00, "R7");

        // R9: SAFE and interrupt sources at once
        step(8'h30, 2'd3, 1'b0, 2'd0, 8'h00, "R9");
        step(8'h00, 2'd3, 1'b1, 2'd3, 8'hFF, "R9");
        step(8'h00, 2'd3, 1'b0, 2'd0, 8'h00, "R9");

        // R6: masked source during PHASE1 is dropped
        step(8'h10, 2'd1, 1'b0, 2'd0, 8'h00, "R6");
        step(8'h10, 2'd1, 1'b0, 2'd0, 8'h00, "R6");
        step(8'h00, 2'd1, 1'b0, 2'd0, 8'h00, "R6");

        // Random mix, each step checks R1 R2 R4 R5 R6 R7 R8 R9 together
        for (int i = 0; i < 400; i++) begin
            step(8'($urandom & $urandom & $urandom), 2'($urandom),
                 ($urandom % 4) == 0, 2'($urandom), 8'($urandom), "R9");
        end

        // R3 / R10: a new reset reopens the mask
        do_reset();
        step(8'h00, 2'd0, 1'b1, 2'd0, 8'h0F, "R3");
        step(8'h01, 2'd2, 1'b0, 2'd0, 8'h00, "R3");
        step(8'h80, 2'd2, 1'b0, 2'd0, 8'h00, "R3");
        step(8'h00, 2'd2, 1'b0, 2'd0, 8'h00, "R3");
        for (int i = 0; i < 300; i++) begin
            step(8'($urandom & $urandom), 2'($urandom),
                 ($urandom % 3) == 0, 2'($urandom), 8'($urandom), "R8");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule